// File: doc/BRIEF.md
# Paired Half-Result Retirement Gate

This block governs how a 128-bit vector operation that executes as two 64-bit halves writes its result into the destination register. Each half reports its completion separately, with its 64-bit result and an exception flag. The halves may finish in either order, in the same cycle, or many cycles apart. The block decides in which cycle each half may be written.

The mode bit latched at issue selects one of two retirement policies. With exceptions unmasked, the halves are coupled. The block holds whichever half finishes first, writes both halves together once the pair is complete and clean, and writes nothing if either half faults. A half-valid destination therefore never appears. With exceptions masked, each half is written as soon as it finishes and its exception flag is ignored, so the early half never stalls waiting for its partner.

A flush input cancels any half that has not yet been written. A busy output blocks a new issue until the current pair has fully retired, faulted or been flushed. All outputs are registered.

Top module: `vec_pair_retire`

## Requirements
- R1: Out of reset, `busy`, `fault` and both bits of `wr_en` are low.
- R2: An issue is accepted only while `busy` is low, and `busy` is high in the next cycle. An issue seen while `busy` is high is ignored and does not change the mode latched for the pair in flight.
- R3: In coupled mode (`issue_mask` = 0 at issue), `wr_en` = 2'b11 appears for one cycle, one cycle after the cycle in which the later of the two halves completes. This holds for either completion order and for simultaneous completion. `wr_data[63:0]` carries the low half and `wr_data[127:64]` the high half.
- R4: In coupled mode, `wr_en` is never 2'b01 or 2'b10.
- R5: In coupled mode, an exception flag on either half's completion raises `fault` for one cycle in the next cycle, produces no write, and leaves the block idle (`busy` low) in that same cycle. A fault raised by the first half does not wait for the second half.
- R6: In masked mode (`issue_mask` = 1 at issue), each half is written one cycle after its own completion, regardless of its exception flag. `wr_en[0]` is the low half and `wr_en[1]` the high half, and `fault` stays low.
- R7: `flush` while busy cancels every half not yet written, including a half completing in the same cycle. No write and no fault follow, and `busy` is low in the next cycle.
- R8: A completion while idle, or a second completion of a half already completed for the current pair, is ignored. The first result of that half is the one written.
- R9: `busy` falls in the same cycle in which the final write or the fault of the pair appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Start a new 128-bit operation |
| issue_mask | input | 1 | Exceptions masked for this operation (1 = independent halves) |
| flush | input | 1 | Cancel any unwritten half |
| lo_done | input | 1 | Low half completes this cycle |
| lo_exc | input | 1 | Low half raised an exception |
| lo_result | input | 64 | Low half result |
| hi_done | input | 1 | High half completes this cycle |
| hi_exc | input | 1 | High half raised an exception |
| hi_result | input | 64 | High half result |
| busy | output | 1 | A pair is in flight; issue is not accepted |
| wr_en | output | 2 | Destination write strobe per half (bit 0 low, bit 1 high) |
| wr_data | output | 128 | Destination write data |
| fault | output | 1 | Pair discarded because of an unmasked exception |

## Verification
The hardest case to reach is a cycle in which a state change collides with a completion. Examples are a flush arriving together with the second half's completion, an issue attempt that changes the mode bit while a coupled pair is half done, or a repeat completion of a half already held. The stimulus aligns these events on the exact cycle by driving both halves' strobes and the control inputs from one task call. Every write or fault the block produces is compared in order against a queue of expected transactions. A partial write or a write that should have been suppressed therefore shows up as an unmatched or mismatched entry.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int NUM_HALVES = 2;
  localparam int LO = 0;
  localparam int HI = 1;

  typedef enum logic {
    MODE_COUPLED = 1'b0,
    MODE_SPLIT   = 1'b1
  } ret_mode_e;
endpackage

// File: rtl/vpr_half_slot.sv
module vpr_half_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         capture,
  input  logic [W-1:0] data_in,
  output logic         held,
  output logic [W-1:0] held_data
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held <= 1'b0;
    end else if (capture) begin
      held <= 1'b1;
    end
  end

  // data store carries no reset so it maps to plain registers
  always_ff @(posedge clk) begin
    if (capture && !held) begin
      held_data <= data_in;
    end
  end
endmodule

// File: rtl/vpr_retire_ctrl.sv
module vpr_retire_ctrl
  import vpr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue_valid,
  input  logic                  issue_mask,
  input  logic                  flush,
  input  logic [NUM_HALVES-1:0] done_in,
  input  logic [NUM_HALVES-1:0] exc_in,
  input  logic [NUM_HALVES-1:0] held,
  output logic [NUM_HALVES-1:0] ev,
  output logic                  clear_slots,
  output logic [NUM_HALVES-1:0] wr_nx,
  output logic                  fault_nx,
  output logic                  active,
  output ret_mode_e             mode
);
  logic                  active_q;
  ret_mode_e             mode_q;
  logic                  accept;
  logic [NUM_HALVES-1:0] seen;
  logic [NUM_HALVES-1:0] exc_ev;
  logic                  any_exc;
  logic                  pair_full;
  logic                  finish;
  logic                  end_pair;

  assign accept    = issue_valid && !active_q;
  assign ev        = done_in & ~held & {NUM_HALVES{active_q}};
  assign seen      = held | ev;
  assign exc_ev    = ev & exc_in;
  assign any_exc   = |exc_ev;
  assign pair_full = &seen;

  always_comb begin
    wr_nx    = '0;
    fault_nx = 1'b0;
    finish   = 1'b0;
    if (mode_q == MODE_SPLIT) begin
      if (!flush) wr_nx = ev;
      finish = pair_full;
    end else begin
      if (!flush && pair_full && !any_exc) wr_nx = '1;
      fault_nx = !flush && any_exc;
      finish   = pair_full || any_exc;
    end
  end

  assign end_pair    = active_q && (flush || finish);
  assign clear_slots = end_pair || accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= MODE_COUPLED;
    end else if (accept) begin
      active_q <= 1'b1;
      mode_q   <= issue_mask ? MODE_SPLIT : MODE_COUPLED;
    end else if (end_pair) begin
      active_q <= 1'b0;
    end
  end

  assign active = active_q;
  assign mode   = mode_q;

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && issue_valid) |=> active_q);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && issue_valid) |=> $stable(mode_q));
endmodule

// File: rtl/vpr_commit_reg.sv
module vpr_commit_reg
  import vpr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_HALVES-1:0]         wr_nx,
  input  logic                          fault_nx,
  input  logic [NUM_HALVES-1:0]         sel_new,
  input  logic [NUM_HALVES-1:0][W-1:0]  new_data,
  input  logic [NUM_HALVES-1:0][W-1:0]  held_data,
  output logic [NUM_HALVES-1:0]         wr_en,
  output logic [NUM_HALVES*W-1:0]       wr_data,
  output logic                          fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en <= '0;
      fault <= 1'b0;
    end else begin
      wr_en <= wr_nx;
      fault <= fault_nx;
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_nx[h]) begin
        wr_data[h*W +: W] <= sel_new[h] ? new_data[h] : held_data[h];
      end
    end
  end

  // R5
  wr_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((|wr_en) && fault));
endmodule

// File: rtl/vec_pair_retire.sv
module vec_pair_retire
  import vpr_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_valid,
  input  logic                issue_mask,
  input  logic                flush,
  input  logic                lo_done,
  input  logic                lo_exc,
  input  logic [HALF_W-1:0]   lo_result,
  input  logic                hi_done,
  input  logic                hi_exc,
  input  logic [HALF_W-1:0]   hi_result,
  output logic                busy,
  output logic [1:0]          wr_en,
  output logic [2*HALF_W-1:0] wr_data,
  output logic                fault
);
  logic [NUM_HALVES-1:0]             done_in;
  logic [NUM_HALVES-1:0]             exc_in;
  logic [NUM_HALVES-1:0][HALF_W-1:0] res_in;
  logic [NUM_HALVES-1:0][HALF_W-1:0] held_data;
  logic [NUM_HALVES-1:0]             held;
  logic [NUM_HALVES-1:0]             ev;
  logic [NUM_HALVES-1:0]             wr_nx;
  logic                              fault_nx;
  logic                              clear_slots;
  ret_mode_e                         mode;

  assign done_in    = {hi_done, lo_done};
  assign exc_in     = {hi_exc, lo_exc};
  assign res_in[LO] = lo_result;
  assign res_in[HI] = hi_result;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_slot
    vpr_half_slot #(.W(HALF_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .clear     (clear_slots),
      .capture   (ev[h]),
      .data_in   (res_in[h]),
      .held      (held[h]),
      .held_data (held_data[h])
    );
  end

  vpr_retire_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_mask  (issue_mask),
    .flush       (flush),
    .done_in     (done_in),
    .exc_in      (exc_in),
    .held        (held),
    .ev          (ev),
    .clear_slots (clear_slots),
    .wr_nx       (wr_nx),
    .fault_nx    (fault_nx),
    .active      (busy),
    .mode        (mode)
  );

  vpr_commit_reg #(.W(HALF_W)) u_commit (
    .clk       (clk),
    .rst       (rst),
    .wr_nx     (wr_nx),
    .fault_nx  (fault_nx),
    .sel_new   (ev),
    .new_data  (res_in),
    .held_data (held_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .fault     (fault)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (wr_en == 2'b00 && !fault && !busy));

  // R4
  no_partial_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mode == MODE_COUPLED) |=> (wr_en != 2'b01 && wr_en != 2'b10));

  // R6
  split_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mode == MODE_SPLIT) |=> !fault);

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && flush) |=> (wr_en == 2'b00 && !fault && !busy));

  // R5
  fault_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> !busy);

  // R8
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (wr_en == 2'b00 && !fault));
endmodule

// File: tb/vec_pair_retire_tb.sv
module vec_pair_retire_tb;
  localparam int W = 64;

  typedef struct packed {
    logic [1:0]     wr;
    logic           flt;
    logic [2*W-1:0] d;
    logic [3:0]     req;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           issue_valid = 1'b0;
  logic           issue_mask = 1'b0;
  logic           flush = 1'b0;
  logic           lo_done = 1'b0;
  logic           lo_exc = 1'b0;
  logic [W-1:0]   lo_result = '0;
  logic           hi_done = 1'b0;
  logic           hi_exc = 1'b0;
  logic [W-1:0]   hi_result = '0;
  logic           busy;
  logic [1:0]     wr_en;
  logic [2*W-1:0] wr_data;
  logic           fault;

  int   checks = 0;
  int   errors = 0;
  bit   done_run = 1'b0;
  bit   mon_on = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  vec_pair_retire #(.HALF_W(W)) u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_mask(issue_mask),
    .flush(flush), .lo_done(lo_done), .lo_exc(lo_exc), .lo_result(lo_result),
    .hi_done(hi_done), .hi_exc(hi_exc), .hi_result(hi_result),
    .busy(busy), .wr_en(wr_en), .wr_data(wr_data), .fault(fault)
  );

  task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_tx(input logic [1:0] wr, input logic flt,
                           input logic [W-1:0] hi, input logic [W-1:0] lo, input int req);
    exp_t e;
    e.wr = wr; e.flt = flt; e.d = {hi, lo}; e.req = 4'(req);
    exp_q.push_back(e);
  endtask

  task automatic issue(input logic m);
    @(negedge clk);
    issue_valid = 1'b1; issue_mask = m;
    @(negedge clk);
    issue_valid = 1'b0; issue_mask = 1'b0;
  endtask

  task automatic step(input logic dl, input logic xl, input logic [W-1:0] vl,
                      input logic dh, input logic xh, input logic [W-1:0] vh,
                      input logic fl);
    @(negedge clk);
    lo_done = dl; lo_exc = xl; lo_result = vl;
    hi_done = dh; hi_exc = xh; hi_result = vh;
    flush = fl;
    @(negedge clk);
    lo_done = 0; lo_exc = 0; hi_done = 0; hi_exc = 0; flush = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: every write or fault must match the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && (wr_en != 2'b00 || fault)) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected output actual wr=%b fault=%b expected none", wr_en, fault);
        end else begin
          exp_t e;
          logic [2*W-1:0] m;
          e = exp_q.pop_front();
          m = {{W{e.wr[1]}}, {W{e.wr[0]}}};
          chk($sformatf("R%0d strobe", e.req), {125'd0, wr_en, fault}, {125'd0, e.wr, e.flt});
          chk($sformatf("R%0d data", e.req), wr_data & m, e.d & m);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {124'd0, busy, wr_en, fault}, '0);
    mon_on = 1'b1;

    // R3 coupled, low first then high later
    issue(1'b0);
    chk("R2 busy after issue", {127'd0, busy}, 128'd1);
    step(1, 0, 64'h1111, 0, 0, 0, 0);
    idle(3);
    expect_tx(2'b11, 0, 64'h2222, 64'h1111, 3);
    step(0, 0, 0, 1, 0, 64'h2222, 0);
    chk("R9 busy low at write", {127'd0, busy}, 128'd0);

    // R3 coupled, high first
    issue(1'b0);
    step(0, 0, 0, 1, 0, 64'hAAAA, 0);
    expect_tx(2'b11, 0, 64'hAAAA, 64'hBBBB, 3);
    step(1, 0, 64'hBBBB, 0, 0, 0, 0);

    // R3 coupled, same cycle
    issue(1'b0);
    expect_tx(2'b11, 0, 64'h4444, 64'h3333, 3);
    step(1, 0, 64'h3333, 1, 0, 64'h4444, 0);

    // R5 second half faults: nothing written
    issue(1'b0);
    step(1, 0, 64'h5555, 0, 0, 0, 0);
    expect_tx(2'b00, 1, 0, 0, 5);
    step(0, 0, 0, 1, 1, 64'h6666, 0);
    chk("R5 idle after fault", {127'd0, busy}, 128'd0);

    // R5 first half faults early; R8 later completion while idle ignored
    issue(1'b0);
    expect_tx(2'b00, 1, 0, 0, 5);
    step(1, 1, 64'h7777, 0, 0, 0, 0);
    chk("R5 early fault idle", {127'd0, busy}, 128'd0);
    step(0, 0, 0, 1, 0, 64'h8888, 0);
    idle(2);

    // R6 masked: independent writes, exception ignored
    issue(1'b1);
    expect_tx(2'b01, 0, 0, 64'h9999, 6);
    step(1, 0, 64'h9999, 0, 0, 0, 0);
    chk("R6 still busy", {127'd0, busy}, 128'd1);
    expect_tx(2'b10, 0, 64'hCCCC, 0, 6);
    step(0, 0, 0, 1, 1, 64'hCCCC, 0);
    chk("R9 busy low after split", {127'd0, busy}, 128'd0);

    // R6 masked, both same cycle
    issue(1'b1);
    expect_tx(2'b11, 0, 64'hDD02, 64'hDD01, 6);
    step(1, 1, 64'hDD01, 1, 0, 64'hDD02, 0);

    // R7 flush in coupled after one half
    issue(1'b0);
    step(1, 0, 64'hEE01, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R7 idle after flush", {127'd0, busy}, 128'd0);
    step(0, 0, 0, 1, 0, 64'hEE02, 0);
    idle(2);

    // R7 flush in masked after low written
    issue(1'b1);
    expect_tx(2'b01, 0, 0, 64'hF001, 6);
    step(1, 0, 64'hF001, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 64'hF002, 0);
    chk("R7 masked flush idle", {127'd0, busy}, 128'd0);

    // R7 flush in same cycle as final completion
    issue(1'b0);
    step(1, 0, 64'h0A01, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 64'h0A02, 1);
    chk("R7 same-cycle flush", {127'd0, busy}, 128'd0);
    idle(2);

    // R2 issue while busy ignored (mode stays coupled)
    issue(1'b0);
    issue(1'b1);
    step(1, 0, 64'h0B01, 0, 0, 0, 0);
    idle(2);
    chk("R2 still coupled", {127'd0, busy}, 128'd1);
    expect_tx(2'b11, 0, 64'h0B02, 64'h0B01, 2);
    step(0, 0, 0, 1, 0, 64'h0B02, 0);

    // R8 repeated completion of held half ignored
    issue(1'b0);
    step(1, 0, 64'h0C01, 0, 0, 0, 0);
    step(1, 1, 64'h0CFF, 0, 0, 0, 0);
    expect_tx(2'b11, 0, 64'h0C02, 64'h0C01, 8);
    step(0, 0, 0, 1, 0, 64'h0C02, 0);

    idle(4);
    chk("R3 all expected outputs seen", 128'(exp_q.size()), 128'd0);
    done_run = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule